// File: doc/BRIEF.md
# Forwarded-Clock Three-Lane Word Deserializer

This block sits on the receive side of a source-synchronous parallel link. The link carries three serial data lanes and one framing lane, and all four are sampled by a local bit clock that runs seven times faster than the word rate. Each rising edge seen on the framing lane marks the start of a word. Seven consecutive samples from each data lane are collected and joined into a 21-bit word. That word is presented together with a one-cycle strobe.

The framing lane alone decides where a word starts; the data contents play no part. The output word is never cleared once the block is running. It holds its last value while the link is powered down, and it also holds while the framing lane has stopped toggling. After a power-down is released, and after reset, a programmable number of complete words is discarded before updates resume. This models the settling time of the upstream lock.

A four-state controller supervises the block:

- `ST_DOWN`: power-down is active.
- `ST_SETTLE`: words are being counted off.
- `ST_RUN`: words are emitted.
- `ST_LOST`: the framing lane is silent.

Transitions:

- `go_down`: any state moves to `ST_DOWN` while `pwr_n` is low.
- `wake`: `ST_DOWN` moves to `ST_SETTLE` once `pwr_n` is high.
- `settled`: `ST_SETTLE` moves to `ST_RUN` once the discarded-word count has reached `settle_words`.
- `drop`: `ST_RUN` moves to `ST_LOST` when loss is flagged.
- `regain`: `ST_LOST` moves to `ST_RUN` once loss clears.

Reset enters `ST_SETTLE`.

Top module: `fclk_deser`

## Requirements
- R1: Data lane k supplies output bits 7k..7k+6, and the sample taken first in a word lands on bit 7k.
- R2: A word begins at the bit clock in which `frame_lane` is sampled 1 and the previous sample was 0. That sample is bit 0, and bits 1..6 are the six samples that follow. Idle bit clocks between words are allowed.
- R3: `word_out` and `word_stb` update together on the seventh bit clock after the one that sampled bit 0, which is one clock after bit 6. `word_stb` is high for exactly one clock per emitted word.
- R4: `word_out` changes only in a clock where `word_stb` is high.
- R5: While `pwr_n` is low, no strobe is produced and `word_out` keeps its previous value.
- R6: After reset, or after `pwr_n` returns high, the first `settle_words` completed words are discarded and later words are emitted. A value of 0 discards none.
- R7: `link_lost` goes high once 14 bit clocks have elapsed since the last framing rising edge (it is still low after 13). While it is high, no word is emitted and `word_out` holds.
- R8: The next framing rising edge clears `link_lost`, and the word it starts is emitted.
- R9: During reset, `word_out` is 0 and `word_stb` and `link_lost` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven per word period |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_n | input | 1 | Active-low power-down |
| settle_words | input | 8 | Number of words discarded after wake-up |
| frame_lane | input | 1 | Sampled forwarded framing lane |
| data_lanes | input | 3 | Sampled serial data lanes, one bit per lane |
| word_out | output | 21 | Reassembled word |
| word_stb | output | 1 | One-clock pulse when word_out updates |
| link_lost | output | 1 | Framing lane silent for the loss window |

## Verification
The bench uses the default three lanes of seven bits and the 14-clock loss window. It sets `settle_words` to 2 so that both discarding after reset and discarding after a power-down release are exercised. It then drops the value to 0 to cover the no-wait case. The short loss window lets the bench walk the gap to exactly 13 and then 14 clocks and watch the flag flip. Random words with random idle gaps of 0 to 2 clocks show that the word boundary follows the framing edge rather than a fixed period.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
    typedef enum logic [1:0] {
        ST_DOWN   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_RUN    = 2'd2,
        ST_LOST   = 2'd3
    } fcd_state_e;
endpackage

// File: rtl/fcd_frame_mon.sv
module fcd_frame_mon #(
    parameter int BITS       = 7,
    parameter int LOSS_LIMIT = 14,
    localparam int IDX_W = (BITS > 1) ? $clog2(BITS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_in,
    output logic             word_start,
    output logic             cap_en,
    output logic [IDX_W-1:0] cap_idx,
    output logic             word_done,
    output logic             link_lost
);
    localparam int CNT_W = $clog2(BITS + 1);
    localparam int GAP_W = $clog2(LOSS_LIMIT + 1);

    logic             frame_q;
    logic [CNT_W-1:0] pos_cnt;
    logic [GAP_W-1:0] gap_cnt;
    logic             done_q;

    assign word_start = frame_in & ~frame_q;

    always_comb begin
        cap_en  = word_start | (pos_cnt < CNT_W'(BITS));
        cap_idx = word_start ? '0 : IDX_W'(pos_cnt);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= 1'b0;
            pos_cnt <= CNT_W'(BITS);
            gap_cnt <= '0;
            done_q  <= 1'b0;
        end else begin
            frame_q <= frame_in;
            if (word_start)
                pos_cnt <= CNT_W'(1);
            else if (pos_cnt < CNT_W'(BITS))
                pos_cnt <= pos_cnt + CNT_W'(1);
            done_q <= cap_en && (cap_idx == IDX_W'(BITS - 1));
            if (word_start)
                gap_cnt <= '0;
            else if (gap_cnt != GAP_W'(LOSS_LIMIT))
                gap_cnt <= gap_cnt + GAP_W'(1);
        end
    end

    assign word_done = done_q;
    assign link_lost = (gap_cnt == GAP_W'(LOSS_LIMIT));

    // a framing edge always clears the loss flag on the next clock
    assert_edge_clears_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        word_start |=> !link_lost);
endmodule

// File: rtl/fcd_lane_cap.sv
module fcd_lane_cap #(
    parameter int LANES = 3,
    parameter int BITS  = 7,
    localparam int IDX_W = (BITS > 1) ? $clog2(BITS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cap_en,
    input  logic [IDX_W-1:0]      cap_idx,
    input  logic [LANES-1:0]      lanes_in,
    output logic [LANES*BITS-1:0] word_buf
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [BITS-1:0] lane_bits;
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_bits <= '0;
            else if (cap_en)
                lane_bits[cap_idx] <= lanes_in[k];
        end
        assign word_buf[k*BITS +: BITS] = lane_bits;
    end
endmodule

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
    import fcd_pkg::*;
#(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_n,
    input  logic [SETTLE_W-1:0] settle_words,
    input  logic                link_lost,
    input  logic                word_done,
    output logic                emit
);
    fcd_state_e          state, state_nxt;
    logic [SETTLE_W-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_SETTLE;
            wcnt  <= '0;
        end else begin
            state <= state_nxt;
            if (state != ST_SETTLE)
                wcnt <= '0;
            else if (word_done && wcnt < settle_words)
                wcnt <= wcnt + SETTLE_W'(1);
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_DOWN:   if (pwr_n)                state_nxt = ST_SETTLE;
            ST_SETTLE: if (wcnt >= settle_words) state_nxt = ST_RUN;
            ST_RUN:    if (link_lost)            state_nxt = ST_LOST;
            ST_LOST:   if (!link_lost)           state_nxt = ST_RUN;
            default:                             state_nxt = ST_SETTLE;
        endcase
        if (!pwr_n)
            state_nxt = ST_DOWN;
    end

    always_comb begin
        emit = (state == ST_RUN) && pwr_n && !link_lost && word_done;
    end
endmodule

// File: rtl/fclk_deser.sv
module fclk_deser #(
    parameter int LANES      = 3,
    parameter int BITS       = 7,
    parameter int LOSS_LIMIT = 14,
    parameter int SETTLE_W   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pwr_n,
    input  logic [SETTLE_W-1:0]   settle_words,
    input  logic                  frame_lane,
    input  logic [LANES-1:0]      data_lanes,
    output logic [LANES*BITS-1:0] word_out,
    output logic                  word_stb,
    output logic                  link_lost
);
    localparam int WORD_W = LANES * BITS;
    localparam int IDX_W  = (BITS > 1) ? $clog2(BITS) : 1;

    logic              word_start, cap_en, word_done, emit;
    logic [IDX_W-1:0]  cap_idx;
    logic [WORD_W-1:0] word_buf;
    logic              past_ok;

    fcd_frame_mon #(.BITS(BITS), .LOSS_LIMIT(LOSS_LIMIT)) u_frame (
        .clk(clk), .rst_n(rst_n), .frame_in(frame_lane),
        .word_start(word_start), .cap_en(cap_en), .cap_idx(cap_idx),
        .word_done(word_done), .link_lost(link_lost)
    );

    fcd_lane_cap #(.LANES(LANES), .BITS(BITS)) u_cap (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_idx(cap_idx),
        .lanes_in(data_lanes), .word_buf(word_buf)
    );

    fcd_ctrl #(.SETTLE_W(SETTLE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .settle_words(settle_words),
        .link_lost(link_lost), .word_done(word_done), .emit(emit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out <= '0;
            word_stb <= 1'b0;
            past_ok  <= 1'b0;
        end else begin
            word_stb <= emit;
            past_ok  <= 1'b1;
            if (emit)
                word_out <= word_buf;
        end
    end

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |=> !word_stb);
    assert_hold_without_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !word_stb) |-> $stable(word_out));
    assert_quiet_in_powerdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_n |=> !word_stb);
    assert_quiet_when_lost_R7: assert property (@(posedge clk) disable iff (!rst_n)
        link_lost |-> !word_stb);
endmodule

// File: tb/fclk_deser_test.sv
module fclk_deser_test;
    logic        clk = 1'b0;
    logic        rst_n, pwr_n, frame_lane;
    logic [7:0]  settle_words;
    logic [2:0]  data_lanes;
    logic [20:0] word_out;
    logic        word_stb, link_lost;

    int checks = 0, errors = 0, cyc = 0, qh = 0, qt = 0;
    logic [20:0] expw [0:511];
    int          expc [0:511];
    logic [20:0] last_w = '0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fclk_deser uut (
        .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .settle_words(settle_words),
        .frame_lane(frame_lane), .data_lanes(data_lanes),
        .word_out(word_out), .word_stb(word_stb), .link_lost(link_lost)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] lane_slice(input logic [20:0] w, input int b);
        lane_slice = {w[14+b], w[7+b], w[b]};
    endfunction

    task automatic send_word(input logic [20:0] w, input bit expect_it);
        int t0 = 0;
        for (int b = 0; b < 7; b++) begin
            @(negedge clk);
            if (b == 0) t0 = cyc + 1;
            frame_lane = (b < 4);
            data_lanes = lane_slice(w, b);
        end
        if (expect_it) begin
            expw[qt] = w;
            expc[qt] = t0 + 7;
            qt++;
            last_w = w;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_lane = 1'b0;
            data_lanes = 3'($urandom);
        end
    endtask

    // strobe monitor: R1/R2/R3 word content and timing, R5/R6 no stray strobes
    always @(negedge clk) begin
        if (rst_n === 1'b1 && word_stb === 1'b1) begin
            if (qh < qt) begin
                chk(word_out == expw[qh], "R1", "word content", 32'(word_out), 32'(expw[qh]));
                chk(cyc == expc[qh], "R3", "strobe cycle", 32'(cyc), 32'(expc[qh]));
                qh++;
            end else begin
                chk(1'b0, "R5_R6", "unexpected strobe", 32'(word_out), 32'h0);
            end
        end
    end

    initial begin
        #(4 * 150000);
        chk(1'b0, "WATCHDOG", "timeout", 32'(cyc), 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; pwr_n = 1'b1; settle_words = 8'd2;
        frame_lane = 1'b0; data_lanes = 3'b0;
        repeat (3) @(negedge clk);
        chk(word_out == 21'h0, "R9", "reset word", 32'(word_out), 32'h0);
        chk(word_stb == 1'b0, "R9", "reset strobe", 32'(word_stb), 32'h0);
        chk(link_lost == 1'b0, "R9", "reset lost", 32'(link_lost), 32'h0);
        rst_n = 1'b1;

        // R6: two words discarded after reset, third emitted
        send_word(21'h0ABCDE, 1'b0);
        send_word(21'h154321, 1'b0);
        send_word(21'h1F0F0F, 1'b1);

        // R1: lane mapping, first sample lowest bit
        send_word(21'h000001, 1'b1);
        send_word(21'h000080, 1'b1);
        send_word(21'h004000, 1'b1);
        send_word(21'h100000, 1'b1);
        send_word(21'h1FFFFF, 1'b1);
        send_word(21'h155555, 1'b1);
        send_word(21'h000000, 1'b1);

        // R2: random words with random idle gaps
        for (int i = 0; i < 60; i++) begin
            send_word(21'($urandom), 1'b1);
            idle(int'($urandom % 3));
        end

        // R7: loss boundary at 13 versus 14 clocks
        send_word(21'h0C3A5F, 1'b1);
        idle(8);
        chk(link_lost == 1'b0, "R7", "lost after 13", 32'(link_lost), 32'h0);
        idle(1);
        chk(link_lost == 1'b1, "R7", "lost after 14", 32'(link_lost), 32'h1);
        idle(5);
        chk(word_out == last_w, "R7", "held while lost", 32'(word_out), 32'(last_w));
        // R8: recovery on next framing edge
        send_word(21'h12468A, 1'b1);
        chk(link_lost == 1'b0, "R8", "lost cleared", 32'(link_lost), 32'h0);
        idle(2);

        // R5: power-down freezes output
        idle(3);
        pwr_n = 1'b0;
        send_word(21'h1ABABA, 1'b0);
        send_word(21'h0DEAD1, 1'b0);
        send_word(21'h0BEEF2, 1'b0);
        chk(word_out == last_w, "R5", "held in power-down", 32'(word_out), 32'(last_w));
        idle(2);
        // R6: two discarded after release
        pwr_n = 1'b1;
        send_word(21'h111111, 1'b0);
        send_word(21'h022222, 1'b0);
        chk(word_out == last_w, "R6", "held while settling", 32'(word_out), 32'(last_w));
        send_word(21'h133333, 1'b1);
        send_word(21'h044444, 1'b1);
        send_word(21'h155555, 1'b1);

        // R6: zero settle count
        idle(3);
        pwr_n = 1'b0;
        settle_words = 8'd0;
        idle(2);
        pwr_n = 1'b1;
        idle(1);
        send_word(21'h0F1E2D, 1'b1);

        idle(10);
        chk(qh == qt, "R3", "all expected words emitted", 32'(qh), 32'(qt));
        chk(word_out == last_w, "R4", "final word held", 32'(word_out), 32'(last_w));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule